// File: doc/BRIEF.md
# Floating-Point Double Store Unit

This unit executes the family of 64-bit floating-point store instructions of a 32-bit-address, big-endian RISC core. An instruction word is presented together with the register-file values it needs. The unit publishes the register indices it wants read, and the surrounding pipeline returns the base GPR, the index GPR and the source FPR on the same cycle. The unit decodes the word, forms the effective address and reorders the FPR bits into byte lanes by address. It then issues one memory write and holds it until the memory side accepts it.

Update forms return the effective address as a GPR write-back in the cycle of the accepted handshake. Words that are not one of the four store encodings are rejected with a one-cycle "not mine" pulse. Two exception pulses are also produced: one for a malformed update form and one for a store attempted while floating point is disabled. None of these three rejections has any side effect.

A single-entry reservation tracker, loaded through its own set input, is cleared by any store that touches a byte of the reserved 8-byte granule.

Top module: `fpd_store_unit`

## Requirements
- R1: Primary opcode = `insn_word[31:26]`. Opcode 54 is the displacement form and 55 the displacement-with-update form. Opcode 31 with `insn_word[10:1]` equal to 727 is the indexed form, and 759 the indexed-with-update form. `insn_word[0]` is ignored. Any other word raises `not_mine` for exactly the cycle after acceptance, and it causes no memory request, no write-back, no `done` and no exception pulse.
- R2: The source FPR index is `insn_word[25:21]`, the base GPR index is `insn_word[20:16]` and the index GPR index is `insn_word[15:11]`. The displacement forms compute EA = base + sign-extended `insn_word[15:0]`. The indexed forms compute EA = base + index. The sum is taken modulo 2^64, and `mem_addr` is its low 32 bits.
- R3: In the two non-update forms, a base field of 0 uses the value zero as the base, whatever `base_val` carries.
- R4: `mem_lanes[8*i+7:8*i]` carries the byte stored at EA+i. Lane 0 is `fpr_val[63:56]` and lane 7 is `fpr_val[7:0]`, bit-exact, with no conversion of any pattern, including NaNs.
- R5: `insn_ready` is high when the unit is idle. An instruction accepted at a clock edge with a store outcome raises `mem_valid` in the following cycle. `mem_valid`, `mem_addr` and `mem_lanes` then stay constant, and `insn_ready` stays low, until a cycle in which `mem_ready` is high. `mem_valid` is low in the cycle after that.
- R6: In the handshake cycle of an update form, `gpr_wb_valid` is high, `gpr_wb_idx` equals the base field and `gpr_wb_data` equals the EA zero-extended to 64 bits. Non-update forms never assert `gpr_wb_valid`.
- R7: `done` is high exactly in the cycle in which `mem_valid` and `mem_ready` are both high.
- R8: A store encoding with a valid form, accepted while `fp_enable` is low, raises `exc_fp_unavail` for the cycle after acceptance and produces no memory request and no write-back.
- R9: An update form with a base field of 0 raises `exc_illegal` for the cycle after acceptance, with no store and no write-back. This check takes priority over the FP-enable check.
- R10: A cycle with `rsv_set` high makes `rsv_valid` high from the next cycle on, with granule `rsv_addr[31:3]`. A completed store whose bytes EA..EA+7 (address arithmetic modulo 2^32) include any byte of that granule clears `rsv_valid`. A store that touches none of its bytes leaves it set.
- R11: When `rsv_set` is high in the same cycle as a store handshake, the new reservation is kept, even if the store conflicts with it.
- R12: An EA of any alignment is stored normally, without an exception.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| insn_valid | input | 1 | Instruction word and operands are present |
| insn_ready | output | 1 | Unit is idle and accepts an instruction |
| insn_word | input | 32 | Instruction word |
| rd_fpr_idx | output | 5 | Source FPR index decoded from the word |
| rd_base_idx | output | 5 | Base GPR index decoded from the word |
| rd_index_idx | output | 5 | Index GPR index decoded from the word |
| base_val | input | 64 | Base GPR value |
| index_val | input | 64 | Index GPR value |
| fpr_val | input | 64 | Source FPR value |
| fp_enable | input | 1 | Floating point enabled |
| rsv_set | input | 1 | Load the reservation tracker |
| rsv_addr | input | 32 | Address to reserve |
| rsv_valid | output | 1 | Reservation is active |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Effective address |
| mem_lanes | output | 64 | Byte lanes, lane i for address EA+i |
| gpr_wb_valid | output | 1 | Base GPR write-back strobe |
| gpr_wb_idx | output | 5 | Base GPR index to write |
| gpr_wb_data | output | 64 | Zero-extended effective address |
| done | output | 1 | Store completed this cycle |
| exc_fp_unavail | output | 1 | Floating-point unavailable pulse |
| exc_illegal | output | 1 | Invalid update form pulse |
| not_mine | output | 1 | Word is not a store of this family |

## Verification
The bench drives each instruction for one cycle and checks the outcome in the cycle right after the accepting edge. That is when `mem_valid` with its address and lanes appears, or else the matching one-cycle rejection pulse. While `mem_ready` is withheld, each following cycle is checked for a held, unchanged request. `done` and the write-back are combinational in the handshake cycle, so the bench checks them 1 ns after raising `mem_ready`, away from any clock edge. The tracker changes at the handshake edge, so `rsv_valid` is checked at the next falling edge against a bench model that tests each of the eight stored bytes separately.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

  localparam logic [5:0] OPC_DISP     = 6'd54;
  localparam logic [5:0] OPC_DISP_UPD = 6'd55;
  localparam logic [5:0] OPC_EXT      = 6'd31;
  localparam logic [9:0] XO_IDX       = 10'd727;
  localparam logic [9:0] XO_IDX_UPD   = 10'd759;
  localparam int unsigned DISP_W      = 16;
  localparam int unsigned RIDX_W      = 5;

  // bit 0: update form, bit 1: indexed form
  typedef enum logic [1:0] {
    FORM_DISP     = 2'b00,
    FORM_DISP_UPD = 2'b01,
    FORM_IDX      = 2'b10,
    FORM_IDX_UPD  = 2'b11
  } form_e;

  typedef enum logic [1:0] {
    OUT_STORE   = 2'd0,
    OUT_NOTMINE = 2'd1,
    OUT_ILLEGAL = 2'd2,
    OUT_FPOFF   = 2'd3
  } outcome_e;

  typedef struct packed {
    logic              hit;
    form_e             form;
    logic [RIDX_W-1:0] fsrc;
    logic [RIDX_W-1:0] base;
    logic [RIDX_W-1:0] idx;
    logic [DISP_W-1:0] disp;
  } dec_t;

  function automatic logic form_updates(form_e f);
    return f[0];
  endfunction

  function automatic logic form_indexed(form_e f);
    return f[1];
  endfunction

endpackage

// File: rtl/fpst_decode.sv
module fpst_decode (
  input  logic [31:0]        insn,
  output fpst_pkg::dec_t     dec
);
  import fpst_pkg::*;

  logic [5:0] opc;
  logic [9:0] xo;
  logic       unused_rc;

  assign opc       = insn[31:26];
  assign xo        = insn[10:1];
  assign unused_rc = insn[0];

  always_comb begin
    dec.fsrc = insn[25:21];
    dec.base = insn[20:16];
    dec.idx  = insn[15:11];
    dec.disp = insn[15:0];
    dec.hit  = 1'b1;
    dec.form = FORM_DISP;
    if (opc == OPC_DISP) begin
      dec.form = FORM_DISP;
    end else if (opc == OPC_DISP_UPD) begin
      dec.form = FORM_DISP_UPD;
    end else if (opc == OPC_EXT && xo == XO_IDX) begin
      dec.form = FORM_IDX;
    end else if (opc == OPC_EXT && xo == XO_IDX_UPD) begin
      dec.form = FORM_IDX_UPD;
    end else begin
      dec.hit  = 1'b0;
    end
  end

endmodule

// File: rtl/fpst_agen.sv
module fpst_agen #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32
) (
  input  fpst_pkg::dec_t  dec,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  output logic [AW-1:0]   ea
);
  import fpst_pkg::*;

  localparam int unsigned EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] sum;
  logic            unused_hi;

  always_comb begin
    if (dec.base == '0 && !form_updates(dec.form)) begin
      base_eff = '0;
    end else begin
      base_eff = base_val;
    end
    if (form_indexed(dec.form)) begin
      offset = index_val;
    end else begin
      offset = {{EXT_W{dec.disp[DISP_W-1]}}, dec.disp};
    end
    sum = base_eff + offset;
  end

  assign ea        = sum[AW-1:0];
  assign unused_hi = ^sum[XLEN-1:AW];

endmodule

// File: rtl/fpst_lanes.sv
module fpst_lanes #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] fpr,
  output logic [XLEN-1:0] lanes
);
  localparam int unsigned NLANE = XLEN / 8;

  // lane g holds the byte for address EA+g; lane 0 is the most significant byte
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[8*g +: 8] = fpr[XLEN-8-8*g +: 8];
  end

endmodule

// File: rtl/fpst_rsv.sv
module fpst_rsv #(
  parameter int unsigned AW      = 32,
  parameter int unsigned GRAN_LG = 3,
  parameter int unsigned NLANE   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          st_fire,
  input  logic [AW-1:0] st_ea,
  output logic          valid
);
  localparam int unsigned GW = AW - GRAN_LG;

  logic [GW-1:0] gran_q, gran_d;
  logic          valid_q, valid_d;
  logic [AW-1:0] st_last;
  logic          hit;
  logic          unused_lo;

  // a store no wider than the granule touches at most its first and last granule
  assign st_last   = st_ea + AW'(NLANE - 1);
  assign hit       = (st_ea[AW-1:GRAN_LG] == gran_q) || (st_last[AW-1:GRAN_LG] == gran_q);
  assign unused_lo = ^set_addr[GRAN_LG-1:0];

  always_comb begin
    valid_d = valid_q;
    gran_d  = gran_q;
    if (set) begin
      valid_d = 1'b1;
      gran_d  = set_addr[AW-1:GRAN_LG];
    end else if (st_fire && hit) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (set) begin
      gran_q <= gran_d;
    end
  end

  assign valid = valid_q;

endmodule

// File: rtl/fpd_store_unit.sv
module fpd_store_unit #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned AW      = 32,
  parameter int unsigned GRAN_LG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [31:0]     insn_word,
  output logic [4:0]      rd_fpr_idx,
  output logic [4:0]      rd_base_idx,
  output logic [4:0]      rd_index_idx,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic [XLEN-1:0] fpr_val,
  input  logic            fp_enable,
  input  logic            rsv_set,
  input  logic [AW-1:0]   rsv_addr,
  output logic            rsv_valid,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_lanes,
  output logic            gpr_wb_valid,
  output logic [4:0]      gpr_wb_idx,
  output logic [XLEN-1:0] gpr_wb_data,
  output logic            done,
  output logic            exc_fp_unavail,
  output logic            exc_illegal,
  output logic            not_mine
);
  import fpst_pkg::*;

  localparam int unsigned NLANE = XLEN / 8;
  localparam int unsigned PAD_W = XLEN - AW;

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dec_t            dec;
  logic [AW-1:0]   ea;
  logic [XLEN-1:0] lanes;
  outcome_e        outcome;
  logic            accept, capture, handshake;

  logic              busy_q, busy_d;
  logic              nm_q, nm_d, ill_q, ill_d, fpoff_q, fpoff_d;
  logic [AW-1:0]     ea_q;
  logic [XLEN-1:0]   lanes_q;
  logic [RIDX_W-1:0] wb_idx_q;
  logic              upd_q;

  fpst_decode u_dec (
    .insn (insn_word),
    .dec  (dec)
  );

  fpst_agen #(.XLEN(XLEN), .AW(AW)) u_agen (
    .dec       (dec),
    .base_val  (base_val),
    .index_val (index_val),
    .ea        (ea)
  );

  fpst_lanes #(.XLEN(XLEN)) u_lanes (
    .fpr   (fpr_val),
    .lanes (lanes)
  );

  fpst_rsv #(.AW(AW), .GRAN_LG(GRAN_LG), .NLANE(NLANE)) u_rsv (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .set      (rsv_set),
    .set_addr (rsv_addr),
    .st_fire  (handshake),
    .st_ea    (ea_q),
    .valid    (rsv_valid)
  );

  assign rd_fpr_idx   = dec.fsrc;
  assign rd_base_idx  = dec.base;
  assign rd_index_idx = dec.idx;

  // outcome priority: foreign word, malformed update form, FP disabled, store
  always_comb begin
    if (!dec.hit) begin
      outcome = OUT_NOTMINE;
    end else if (form_updates(dec.form) && dec.base == '0) begin
      outcome = OUT_ILLEGAL;
    end else if (!fp_enable) begin
      outcome = OUT_FPOFF;
    end else begin
      outcome = OUT_STORE;
    end
  end

  assign accept    = insn_valid && !busy_q;
  assign capture   = accept && (outcome == OUT_STORE);
  assign handshake = busy_q && mem_ready;

  always_comb begin
    busy_d = busy_q;
    if (handshake) begin
      busy_d = 1'b0;
    end else if (capture) begin
      busy_d = 1'b1;
    end
    nm_d    = accept && (outcome == OUT_NOTMINE);
    ill_d   = accept && (outcome == OUT_ILLEGAL);
    fpoff_d = accept && (outcome == OUT_FPOFF);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      busy_q  <= 1'b0;
      nm_q    <= 1'b0;
      ill_q   <= 1'b0;
      fpoff_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      nm_q    <= nm_d;
      ill_q   <= ill_d;
      fpoff_q <= fpoff_d;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      ea_q     <= ea;
      lanes_q  <= lanes;
      wb_idx_q <= dec.base;
      upd_q    <= form_updates(dec.form);
    end
  end

  assign insn_ready     = !busy_q;
  assign mem_valid      = busy_q;
  assign mem_addr       = ea_q;
  assign mem_lanes      = lanes_q;
  assign done           = handshake;
  assign gpr_wb_valid   = handshake && upd_q;
  assign gpr_wb_idx     = wb_idx_q;
  assign gpr_wb_data    = {{PAD_W{1'b0}}, ea_q};
  assign exc_fp_unavail = fpoff_q;
  assign exc_illegal    = ill_q;
  assign not_mine       = nm_q;

endmodule

// File: rtl/fpst_checker.sv
module fpst_checker #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_ready,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [XLEN-1:0] mem_lanes,
  input logic            done,
  input logic            gpr_wb_valid,
  input logic [XLEN-1:0] gpr_wb_data,
  input logic            exc_fp_unavail,
  input logic            exc_illegal,
  input logic            not_mine,
  input logic            rsv_set,
  input logic            rsv_valid
);

  a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_lanes)));

  a_r5_busy_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !insn_ready);

  a_r7_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_valid);

  a_r6_wb_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_wb_valid |-> (done && (gpr_wb_data >> AW) == '0));

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, exc_fp_unavail, exc_illegal, not_mine}));

  a_r1_reject_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (not_mine || exc_illegal || exc_fp_unavail) |-> !mem_valid);

  a_r10_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_set |=> rsv_valid);

endmodule

bind fpd_store_unit fpst_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_q),
  .insn_ready     (insn_ready),
  .mem_valid      (mem_valid),
  .mem_ready      (mem_ready),
  .mem_addr       (mem_addr),
  .mem_lanes      (mem_lanes),
  .done           (done),
  .gpr_wb_valid   (gpr_wb_valid),
  .gpr_wb_data    (gpr_wb_data),
  .exc_fp_unavail (exc_fp_unavail),
  .exc_illegal    (exc_illegal),
  .not_mine       (not_mine),
  .rsv_set        (rsv_set),
  .rsv_valid      (rsv_valid)
);

// File: tb/fpd_store_unit_tb.sv
`timescale 1ns/1ps
module fpd_store_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid, insn_ready;
  logic [31:0] insn_word;
  logic [4:0]  rd_fpr_idx, rd_base_idx, rd_index_idx;
  logic [63:0] base_val, index_val, fpr_val;
  logic        fp_enable, rsv_set, rsv_valid;
  logic [31:0] rsv_addr;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr;
  logic [63:0] mem_lanes;
  logic        gpr_wb_valid;
  logic [4:0]  gpr_wb_idx;
  logic [63:0] gpr_wb_data;
  logic        done, exc_fp_unavail, exc_illegal, not_mine;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  int unsigned cyc = 0;

  bit          m_rv = 1'b0;
  logic [28:0] m_rg = '0;

  always #2.5 clk = ~clk;

  fpd_store_unit u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .rd_fpr_idx(rd_fpr_idx), .rd_base_idx(rd_base_idx),
    .rd_index_idx(rd_index_idx), .base_val(base_val), .index_val(index_val),
    .fpr_val(fpr_val), .fp_enable(fp_enable), .rsv_set(rsv_set), .rsv_addr(rsv_addr),
    .rsv_valid(rsv_valid), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_lanes(mem_lanes), .gpr_wb_valid(gpr_wb_valid),
    .gpr_wb_idx(gpr_wb_idx), .gpr_wb_data(gpr_wb_data), .done(done),
    .exc_fp_unavail(exc_fp_unavail), .exc_illegal(exc_illegal), .not_mine(not_mine)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: run hung act=%0d exp<%0d cycles", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // encoders
  function automatic logic [31:0] mk_d(logic [5:0] opc, logic [4:0] fs, logic [4:0] ra, logic [15:0] d);
    return {opc, fs, ra, d};
  endfunction

  function automatic logic [31:0] mk_x(logic [4:0] fs, logic [4:0] ra, logic [4:0] rb, logic [9:0] xo, logic rc);
    return {6'd31, fs, ra, rb, xo, rc};
  endfunction

  function automatic bit is_upd(logic [31:0] w);
    return (w[31:26] == 6'd55) || (w[31:26] == 6'd31 && w[10:1] == 10'd759);
  endfunction

  // 0 store, 1 not mine, 2 illegal, 3 FP off
  function automatic int cls(logic [31:0] w, bit fpen);
    bit hit;
    hit = (w[31:26] == 6'd54) || (w[31:26] == 6'd55) ||
          (w[31:26] == 6'd31 && (w[10:1] == 10'd727 || w[10:1] == 10'd759));
    if (!hit) return 1;
    if (is_upd(w) && w[20:16] == 5'd0) return 2;
    if (!fpen) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] exp_ea(logic [31:0] w, logic [63:0] b, logic [63:0] x);
    logic [63:0] bb, off, s;
    bb  = (w[20:16] == 5'd0 && !is_upd(w)) ? 64'd0 : b;
    off = (w[31:26] == 6'd31) ? x : {{48{w[15]}}, w[15:0]};
    s   = bb + off;
    return s[31:0];
  endfunction

  function automatic logic [63:0] exp_lanes(logic [63:0] f);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = f[63-8*i -: 8];
    return r;
  endfunction

  function automatic bit touches(logic [31:0] ea, logic [28:0] g);
    logic [31:0] a;
    for (int i = 0; i < 8; i++) begin
      a = ea + 32'(i);
      if (a[31:3] == g) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic set_rsv(logic [31:0] a);
    @(negedge clk);
    rsv_set = 1'b1;
    rsv_addr = a;
    @(negedge clk);
    rsv_set = 1'b0;
    m_rv = 1'b1;
    m_rg = a[31:3];
    chk("R10 reservation set", rsv_valid, 1'b1);
  endtask

  task automatic do_insn(logic [31:0] w, logic [63:0] b, logic [63:0] x, logic [63:0] f,
                         bit fpen, int waitc, bit hs_set, logic [31:0] hs_addr);
    int c;
    logic [31:0] ea;
    c  = cls(w, fpen);
    ea = exp_ea(w, b, x);
    @(negedge clk);
    insn_valid = 1'b1;
    insn_word  = w;
    base_val   = b;
    index_val  = x;
    fpr_val    = f;
    fp_enable  = fpen;
    @(negedge clk);
    insn_valid = 1'b0;
    insn_word  = $urandom;
    base_val   = {$urandom, $urandom};
    index_val  = {$urandom, $urandom};
    fpr_val    = {$urandom, $urandom};
    fp_enable  = $urandom;
    chk("R1 not_mine pulse", not_mine, c == 1);
    chk("R9 exc_illegal pulse", exc_illegal, c == 2);
    chk("R8 exc_fp_unavail pulse", exc_fp_unavail, c == 3);
    if (c != 0) begin
      chk("R1 R8 R9 no store on reject", {mem_valid, gpr_wb_valid, done}, 3'b000);
    end else begin
      chk("R5 request raised", mem_valid, 1'b1);
      chk("R5 issue blocked while busy", insn_ready, 1'b0);
      chk("R2 R3 R12 effective address", mem_addr, ea);
      chk("R4 byte lanes", mem_lanes, exp_lanes(f));
      for (int k = 0; k < waitc; k++) begin
        @(negedge clk);
        chk("R5 request held", {mem_valid, done}, 2'b10);
        chk("R5 address stable", mem_addr, ea);
        chk("R5 lanes stable", mem_lanes, exp_lanes(f));
      end
      mem_ready = 1'b1;
      if (hs_set) begin
        rsv_set  = 1'b1;
        rsv_addr = hs_addr;
      end
      #1;
      chk("R7 done on handshake", done, 1'b1);
      chk("R6 write-back strobe", gpr_wb_valid, is_upd(w));
      if (is_upd(w)) begin
        chk("R6 write-back index", gpr_wb_idx, w[20:16]);
        chk("R6 write-back data", gpr_wb_data, {32'd0, ea});
      end
      @(negedge clk);
      mem_ready = 1'b0;
      rsv_set   = 1'b0;
      chk("R5 request retired", {mem_valid, done, insn_ready}, 3'b001);
      if (hs_set) begin
        m_rv = 1'b1;
        m_rg = hs_addr[31:3];
      end else if (m_rv && touches(ea, m_rg)) begin
        m_rv = 1'b0;
      end
      chk(hs_set ? "R11 set wins over store" : "R10 reservation after store", rsv_valid, m_rv);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    insn_valid = 1'b0; insn_word = '0; base_val = '0; index_val = '0; fpr_val = '0;
    fp_enable = 1'b0; rsv_set = 1'b0; rsv_addr = '0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 reset idle", {mem_valid, insn_ready, done, gpr_wb_valid}, 4'b0100);
    chk("R10 reset no reservation", rsv_valid, 1'b0);
    chk("R1 reset no pulses", {not_mine, exc_illegal, exc_fp_unavail}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 literal zero base, R2 wrap below zero
    do_insn(mk_d(6'd54, 5'd3, 5'd0, 16'hFFF8), 64'h1234_5678_9ABC_DEF0, 64'd0,
            64'h3FF0_0000_0000_0000, 1'b1, 0, 1'b0, 32'd0);
    do_insn(mk_x(5'd4, 5'd0, 5'd7, 10'd727, 1'b1), 64'hFFFF_0000_FFFF_0000,
            64'hAAAA_BBBB_0000_4000, 64'h0123_4567_89AB_CDEF, 1'b1, 2, 1'b0, 32'd0);
    // R9 illegal update with base 0, priority over FP off
    do_insn(mk_d(6'd55, 5'd1, 5'd0, 16'h0010), 64'h100, 64'd0, 64'd1, 1'b0, 0, 1'b0, 32'd0);
    do_insn(mk_x(5'd1, 5'd0, 5'd2, 10'd759, 1'b0), 64'h100, 64'h8, 64'd1, 1'b1, 0, 1'b0, 32'd0);
    // R8 FP disabled
    do_insn(mk_d(6'd54, 5'd2, 5'd5, 16'h0008), 64'h2000, 64'd0, 64'd7, 1'b0, 0, 1'b0, 32'd0);
    // R1 foreign words
    do_insn(mk_x(5'd1, 5'd2, 5'd3, 10'd728, 1'b0), 64'h40, 64'h8, 64'd2, 1'b1, 0, 1'b0, 32'd0);
    do_insn(mk_d(6'd0, 5'd1, 5'd2, 16'h0), 64'h40, 64'd0, 64'd2, 1'b1, 0, 1'b0, 32'd0);
    // R6 update form write-back, R2 64-bit wrap of indexed sum
    do_insn(mk_d(6'd55, 5'd9, 5'd12, 16'h0010), 64'h1000, 64'd0, 64'hFFF0_0000_0000_0000, 1'b1, 1, 1'b0, 32'd0);
    do_insn(mk_x(5'd9, 5'd13, 5'd14, 10'd759, 1'b0), 64'hFFFF_FFFF_FFFF_FFF0,
            64'h20, 64'h8000_0000_0000_0000, 1'b1, 3, 1'b0, 32'd0);
    // R4 signalling NaN bit-exact, R12 unaligned
    do_insn(mk_d(6'd54, 5'd6, 5'd8, 16'h0003), 64'h1000, 64'd0, 64'h7FF0_0000_0000_0001, 1'b1, 0, 1'b0, 32'd0);
    // R10 granule conflicts: straddle clears, neighbours keep
    set_rsv(32'h0000_200C);
    do_insn(mk_d(6'd54, 5'd1, 5'd8, 16'h2000), 64'h0, 64'd0, 64'd5, 1'b1, 0, 1'b0, 32'd0);
    do_insn(mk_d(6'd54, 5'd1, 5'd8, 16'h2010), 64'h0, 64'd0, 64'd5, 1'b1, 0, 1'b0, 32'd0);
    do_insn(mk_d(6'd54, 5'd1, 5'd8, 16'h2003), 64'h0, 64'd0, 64'd5, 1'b1, 1, 1'b0, 32'd0);
    chk("R10 straddling store cleared", rsv_valid, 1'b0);
    set_rsv(32'hFFFF_FFF9);
    do_insn(mk_x(5'd1, 5'd0, 5'd3, 10'd727, 1'b0), 64'h0, 64'hFFFF_FFF8, 64'd5, 1'b1, 0, 1'b0, 32'd0);
    // R11 set in the handshake cycle with a conflicting store
    do_insn(mk_d(6'd54, 5'd1, 5'd8, 16'h3000), 64'h0, 64'd0, 64'd5, 1'b1, 1, 1'b1, 32'h0000_3004);

    // constrained random
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w, ea_r;
      logic [63:0] b, x, f;
      int sel;
      bit fpen;
      logic [4:0] ra;
      sel  = $urandom_range(0, 9);
      ra   = ($urandom_range(0, 5) == 0) ? 5'd0 : 5'($urandom);
      b    = ($urandom_range(0, 3) == 0) ? {32'hFFFF_FFFF, $urandom} : {$urandom, $urandom};
      x    = {$urandom, $urandom};
      f    = {$urandom, $urandom};
      fpen = ($urandom_range(0, 7) != 0);
      case (sel)
        0, 1:    w = mk_d(6'd54, 5'($urandom), ra, 16'($urandom));
        2, 3:    w = mk_d(6'd55, 5'($urandom), ra, 16'($urandom));
        4, 5:    w = mk_x(5'($urandom), ra, 5'($urandom), 10'd727, 1'($urandom));
        6, 7:    w = mk_x(5'($urandom), ra, 5'($urandom), 10'd759, 1'($urandom));
        8: begin
          w = $urandom;
          if (w[31:26] == 6'd54 || w[31:26] == 6'd55) w[31:26] = 6'd12;
          if (w[31:26] == 6'd31 && (w[10:1] == 10'd727 || w[10:1] == 10'd759)) w[10:1] = 10'd0;
        end
        default: w = mk_x(5'($urandom), ra, 5'($urandom), 10'($urandom_range(700, 790)), 1'b0);
      endcase
      ea_r = exp_ea(w, b, x);
      if ($urandom_range(0, 3) == 0) set_rsv(ea_r + 32'($urandom_range(0, 24)) - 32'd12);
      do_insn(w, b, x, f, fpen, $urandom_range(0, 3), ($urandom_range(0, 15) == 0),
              ea_r ^ 32'($urandom_range(0, 15)));
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule